// File: doc/BRIEF.md
# ALU with Processor Status Flags

This block pairs a byte-wide arithmetic and logic unit with the eight-bit processor status register that records what the last operation produced. Each cycle, the execute stage presents an operation code, two operands and a bit selector. The block returns the result combinationally. When the flag-write strobe is high, it updates the status flags at the next clock edge. The flags cover carry, zero, negative, signed overflow, sign and half carry, plus a user copy bit and the global interrupt enable.

The interrupt enable is also driven by hardware. An interrupt acknowledge clears it, and the return-from-interrupt operation sets it again. Entering and leaving an interrupt changes no other flag, so software must save and restore the arithmetic flags itself. A simple bus port makes the whole register readable and writable at one fixed address. A bus write takes precedence over everything else in the same cycle.

Top module: `alu_status_unit`

## Requirements
- R1: After reset the status register reads 0x00. Its bit layout from bit 7 down to bit 0 is: interrupt enable, copy bit, half carry, sign, overflow, negative, zero, carry.
- R2: Code 0 (add) and code 1 (add with carry-in from bit 0) return the byte sum. They set C on carry out of bit 7 and H on carry out of bit 3. V is set when both operands share a sign that differs from the result sign.
- R3: Code 2 (subtract) and code 3 (subtract with borrow-in from bit 0) return A-B-borrow. They set C when the unsigned subtrahend plus borrow exceeds A, and H when a borrow crosses out of the low nibble. V is set when the operand signs differ and the result sign differs from A.
- R4: For codes 0 to 6, N takes the result MSB, Z is set for a zero result, and S equals N xor V.
- R5: Codes 4, 5 and 6 (AND, OR, XOR) clear V and leave C and H unchanged.
- R6: With the flag-write strobe low and no interrupt acknowledge or bus write, the status register holds its value. Code 7 returns operand B and changes no flag.
- R7: Code 8 copies bit `bitsel` of A into the copy bit (bit 6) and returns A. No other flag changes.
- R8: Code 9 returns A with bit `bitsel` replaced by the copy bit. No flag changes.
- R9: Code 10 and code 12 (return from interrupt) set bit 7. Code 11 clears it. None of them touch the other flags.
- R10: An interrupt acknowledge clears bit 7 at the next edge, even if code 10 or 12 is written in the same cycle. Any other flag change from the operation still takes effect.
- R11: A bus read returns the status register when the address is 0x5F, and 0x00 at any other address. The read path is combinational.
- R12: A bus write at address 0x5F loads all eight bits and overrides both the operation and the interrupt acknowledge in that cycle. A bus write at any other address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| bitsel_i | input | 3 | Bit selector for the copy-bit operations |
| flag_we_i | input | 1 | Applies the operation's flag effects at the next edge |
| irq_ack_i | input | 1 | Interrupt taken; clears the interrupt enable |
| result_o | output | 8 | Operation result |
| sreg_o | output | 8 | Current status register |
| bus_addr_i | input | 8 | Bus address |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data |

## Verification
Every flag is visible on `sreg_o` one edge after the cycle that changed it. A wrong carry, half-carry or overflow therefore shows up in the next cycle, and it also feeds the next add-with-carry or subtract-with-borrow result. A bad copy bit shows up one cycle later in a bit-load result. A wrong priority among the bus write, the interrupt acknowledge and the operation appears as a wrong bit 7 or a wrong full byte right after the conflicting cycle. Randomised operation sequences are chained without reset, so any stale or corrupted flag propagates into later results.

// File: rtl/asf_pkg.sv
package asf_pkg;

   localparam int unsigned SREG_W = 8;

   // Status bit positions; bit order is fixed by software convention.
   localparam int unsigned B_C = 0;
   localparam int unsigned B_Z = 1;
   localparam int unsigned B_N = 2;
   localparam int unsigned B_V = 3;
   localparam int unsigned B_S = 4;
   localparam int unsigned B_H = 5;
   localparam int unsigned B_T = 6;
   localparam int unsigned B_I = 7;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_MOV  = 4'd7,
      OP_BST  = 4'd8,
      OP_BLD  = 4'd9,
      OP_SEI  = 4'd10,
      OP_CLI  = 4'd11,
      OP_RETI = 4'd12,
      OP_NOP  = 4'd15
   } op_e;

   function automatic logic is_arith(input op_e op);
      return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
   endfunction

   function automatic logic is_logic(input op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   endfunction

endpackage

// File: rtl/asf_adder.sv
module asf_adder #(
   parameter int unsigned W       = 8,
   parameter int unsigned HC_BIT  = 3,
   parameter bit          RIPPLE  = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         chalf_o,
   output logic         cout_o
);

   localparam int unsigned LOW_W = HC_BIT + 1;

   initial begin
      assert (HC_BIT + 1 < W) else $fatal(1, "half-carry bit must lie below the MSB");
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] carry;
         assign carry[0] = cin_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
            assign carry[i+1]   = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
         end
         assign cout_o  = carry[W];
         assign chalf_o = carry[LOW_W];
      end else begin : g_behav
         logic [W:0]     full;
         logic [LOW_W:0] low;
         assign full    = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
         assign low     = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]}
                        + {{LOW_W{1'b0}}, cin_i};
         assign sum_o   = full[W-1:0];
         assign cout_o  = full[W];
         assign chalf_o = low[LOW_W];
      end
   endgenerate

endmodule

// File: rtl/asf_alu.sv
module asf_alu
   import asf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned HC_BIT = 3,
   parameter bit          RIPPLE = 1'b0,
   localparam int unsigned SEL_W = $clog2(DATA_W)
) (
   input  op_e               op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [SEL_W-1:0]  bitsel_i,
   input  logic [SREG_W-1:0] sreg_i,
   output logic [DATA_W-1:0] result_o,
   output logic [SREG_W-1:0] flags_o
);

   localparam int unsigned MSB = DATA_W - 1;

   logic              sub_sel;
   logic [DATA_W-1:0] b_eff;
   logic              cin;
   logic [DATA_W-1:0] sum;
   logic              chalf;
   logic              cout;

   assign sub_sel = (op_i == OP_SUB) || (op_i == OP_SBC);
   assign b_eff   = sub_sel ? ~b_i : b_i;

   always_comb begin
      unique case (op_i)
         OP_ADC:  cin = sreg_i[B_C];
         OP_SUB:  cin = 1'b1;
         OP_SBC:  cin = ~sreg_i[B_C];
         default: cin = 1'b0;
      endcase
   end

   asf_adder #(
      .W      (DATA_W),
      .HC_BIT (HC_BIT),
      .RIPPLE (RIPPLE)
   ) adder_i (
      .a_i     (a_i),
      .b_i     (b_eff),
      .cin_i   (cin),
      .sum_o   (sum),
      .chalf_o (chalf),
      .cout_o  (cout)
   );

   always_comb begin
      flags_o  = sreg_i;
      result_o = a_i;
      case (op_i)
         OP_ADD, OP_ADC: begin
            result_o       = sum;
            flags_o[B_C]   = cout;
            flags_o[B_H]   = chalf;
            flags_o[B_V]   = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
         end
         OP_SUB, OP_SBC: begin
            result_o       = sum;
            flags_o[B_C]   = ~cout;
            flags_o[B_H]   = ~chalf;
            flags_o[B_V]   = (a_i[MSB] != b_i[MSB]) && (sum[MSB] != a_i[MSB]);
         end
         OP_AND: begin
            result_o     = a_i & b_i;
            flags_o[B_V] = 1'b0;
         end
         OP_OR: begin
            result_o     = a_i | b_i;
            flags_o[B_V] = 1'b0;
         end
         OP_XOR: begin
            result_o     = a_i ^ b_i;
            flags_o[B_V] = 1'b0;
         end
         OP_MOV:  result_o = b_i;
         OP_BST:  flags_o[B_T] = a_i[bitsel_i];
         OP_BLD:  result_o[bitsel_i] = sreg_i[B_T];
         OP_SEI, OP_RETI: flags_o[B_I] = 1'b1;
         OP_CLI:  flags_o[B_I] = 1'b0;
         default: result_o = a_i;
      endcase
      if (is_arith(op_i) || is_logic(op_i)) begin
         flags_o[B_N] = result_o[MSB];
         flags_o[B_Z] = (result_o == '0);
         flags_o[B_S] = result_o[MSB] ^ flags_o[B_V];
      end
   end

endmodule

// File: rtl/asf_sreg.sv
module asf_sreg
   import asf_pkg::*;
#(
   parameter int unsigned          ADDR_W      = 8,
   parameter logic [ADDR_W-1:0]    FLAG_ADDR   = 'h5F,
   parameter logic [ADDR_W-1:0]    IO_OFFSET   = 'h20,
   parameter bit                   USE_IO_ADDR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en_i,
   input  logic [SREG_W-1:0] upd_flags_i,
   input  logic              irq_ack_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [SREG_W-1:0] bus_wdata_i,
   output logic [SREG_W-1:0] bus_rdata_o,
   output logic              bus_wr_hit_o,
   output logic [SREG_W-1:0] sreg_o
);

   logic              addr_hit;
   logic [SREG_W-1:0] sreg_q;
   logic [SREG_W-1:0] sreg_d;
   logic [SREG_W-1:0] op_next;

   generate
      if (USE_IO_ADDR) begin : g_io_decode
         localparam logic [ADDR_W-1:0] MATCH = FLAG_ADDR - IO_OFFSET;
         assign addr_hit = (bus_addr_i == MATCH);
      end else begin : g_data_decode
         assign addr_hit = (bus_addr_i == FLAG_ADDR);
      end
   endgenerate

   assign bus_wr_hit_o = bus_wr_i && addr_hit;

   always_comb begin
      op_next = upd_en_i ? upd_flags_i : sreg_q;
      if (irq_ack_i) begin
         op_next[B_I] = 1'b0;
      end
      sreg_d = bus_wr_hit_o ? bus_wdata_i : op_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
      end else begin
         sreg_q <= sreg_d;
      end
   end

   assign sreg_o      = sreg_q;
   assign bus_rdata_o = addr_hit ? sreg_q : '0;

   AST_BUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_hit_o |=> (sreg_q == $past(bus_wdata_i))); // R12

   AST_IRQ_CLEARS_I: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !bus_wr_hit_o) |=> !sreg_q[B_I]); // R10

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en_i && !irq_ack_i && !bus_wr_hit_o) |=> $stable(sreg_q)); // R6

   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_hit |-> (bus_rdata_o == '0)); // R11

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
   import asf_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       HC_BIT      = 3,
   parameter bit                RIPPLE      = 1'b0,
   parameter int unsigned       ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] FLAG_ADDR   = 'h5F,
   parameter logic [ADDR_W-1:0] IO_OFFSET   = 'h20,
   parameter bit                USE_IO_ADDR = 1'b0,
   localparam int unsigned      SEL_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [SEL_W-1:0]  bitsel_i,
   input  logic              flag_we_i,
   input  logic              irq_ack_i,
   output logic [DATA_W-1:0] result_o,
   output logic [7:0]        sreg_o,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o
);

   initial begin
      assert (DATA_W >= 5) else $fatal(1, "DATA_W too small for a half-carry nibble");
      assert (ADDR_W >= 7) else $fatal(1, "ADDR_W too small for the register address");
      assert (SREG_W == 8) else $fatal(1, "status register must be one byte");
   end

   op_e               op;
   logic [SREG_W-1:0] sreg;
   logic [SREG_W-1:0] alu_flags;
   logic              bus_hit;

   assign op = op_e'(op_i);

   asf_alu #(
      .DATA_W (DATA_W),
      .HC_BIT (HC_BIT),
      .RIPPLE (RIPPLE)
   ) alu_i (
      .op_i     (op),
      .a_i      (opa_i),
      .b_i      (opb_i),
      .bitsel_i (bitsel_i),
      .sreg_i   (sreg),
      .result_o (result_o),
      .flags_o  (alu_flags)
   );

   asf_sreg #(
      .ADDR_W      (ADDR_W),
      .FLAG_ADDR   (FLAG_ADDR),
      .IO_OFFSET   (IO_OFFSET),
      .USE_IO_ADDR (USE_IO_ADDR)
   ) sreg_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .upd_en_i     (flag_we_i),
      .upd_flags_i  (alu_flags),
      .irq_ack_i    (irq_ack_i),
      .bus_addr_i   (bus_addr_i),
      .bus_wr_i     (bus_wr_i),
      .bus_wdata_i  (bus_wdata_i),
      .bus_rdata_o  (bus_rdata_o),
      .bus_wr_hit_o (bus_hit),
      .sreg_o       (sreg)
   );

   assign sreg_o = sreg;

   AST_SIGN_IS_N_XOR_V: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && !bus_hit && (is_arith(op) || is_logic(op)))
      |=> (sreg[B_S] == (sreg[B_N] ^ sreg[B_V]))); // R4

   AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && !bus_hit && is_logic(op))
      |=> (!sreg[B_V] && sreg[B_C] == $past(sreg[B_C]) && sreg[B_H] == $past(sreg[B_H]))); // R5

   AST_BST_ONLY_T: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && !bus_hit && !irq_ack_i && op == OP_BST)
      |=> ({sreg[B_I], sreg[B_H:0]} == $past({sreg[B_I], sreg[B_H:0]}))); // R7

   AST_MOV_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && !bus_hit && !irq_ack_i && op == OP_MOV) |=> $stable(sreg)); // R6

endmodule

// File: tb/alu_status_unit_tb_top.sv
module alu_status_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] op_i;
   logic [7:0] opa_i, opb_i;
   logic [2:0] bitsel_i;
   logic       flag_we_i, irq_ack_i;
   logic [7:0] result_o, sreg_o;
   logic [7:0] bus_addr_i, bus_wdata_i, bus_rdata_o;
   logic       bus_wr_i;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_sreg;

   always #4 clk = ~clk;

   alu_status_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op_i),
      .opa_i       (opa_i),
      .opb_i       (opb_i),
      .bitsel_i    (bitsel_i),
      .flag_we_i   (flag_we_i),
      .irq_ack_i   (irq_ack_i),
      .result_o    (result_o),
      .sreg_o      (sreg_o),
      .bus_addr_i  (bus_addr_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // Expected {result, flags} from the requirement text.
   function automatic logic [15:0] ref_op(input int op, input logic [7:0] a, input logic [7:0] b,
                                           input int bs, input logic [7:0] s);
      logic [7:0] f;
      logic [7:0] r;
      int ai, bi, cin, t;
      logic upd_nz;
      f = s; r = a; ai = int'(a); bi = int'(b); upd_nz = 1'b0; cin = 0;
      case (op)
         0, 1: begin  // R2
            cin  = (op == 1) ? int'(s[0]) : 0;
            t    = ai + bi + cin;
            r    = t[7:0];
            f[0] = (t > 255);
            f[5] = ((ai % 16) + (bi % 16) + cin) > 15;
            f[3] = (a[7] == b[7]) && (r[7] != a[7]);
            upd_nz = 1'b1;
         end
         2, 3: begin  // R3
            cin  = (op == 3) ? int'(s[0]) : 0;
            t    = ai - bi - cin;
            r    = t[7:0];
            f[0] = (ai < bi + cin);
            f[5] = ((ai % 16) < (bi % 16) + cin);
            f[3] = (a[7] != b[7]) && (r[7] != a[7]);
            upd_nz = 1'b1;
         end
         4: begin r = a & b; f[3] = 1'b0; upd_nz = 1'b1; end  // R5
         5: begin r = a | b; f[3] = 1'b0; upd_nz = 1'b1; end
         6: begin r = a ^ b; f[3] = 1'b0; upd_nz = 1'b1; end
         7: r = b;                 // R6
         8: f[6] = a[bs];          // R7
         9: r[bs] = s[6];          // R8
         10, 12: f[7] = 1'b1;      // R9
         11: f[7] = 1'b0;
         default: r = a;
      endcase
      if (upd_nz) begin  // R4
         f[2] = r[7];
         f[1] = (r == 8'h00);
         f[4] = f[2] ^ f[3];
      end
      return {r, f};
   endfunction

   task automatic step(input string req, input int op, input logic [7:0] a, input logic [7:0] b,
                       input int bs, input logic we, input logic irq,
                       input logic bwr, input logic [7:0] baddr, input logic [7:0] bwd);
      logic [15:0] exp;
      logic [7:0]  nxt;
      op_i = 4'(op); opa_i = a; opb_i = b; bitsel_i = 3'(bs);
      flag_we_i = we; irq_ack_i = irq;
      bus_wr_i = bwr; bus_addr_i = baddr; bus_wdata_i = bwd;
      #2;
      exp = ref_op(op, a, b, bs, m_sreg);
      chk({req, " result"}, result_o, exp[15:8]);
      chk({req, " R11 bus read"}, bus_rdata_o, (baddr == 8'h5F) ? m_sreg : 8'h00);
      nxt = we ? exp[7:0] : m_sreg;
      if (irq) nxt[7] = 1'b0;               // R10
      if (bwr && baddr == 8'h5F) nxt = bwd; // R12
      @(posedge clk);
      #2;
      m_sreg = nxt;
      chk({req, " flags"}, sreg_o, m_sreg);
      bus_wr_i = 1'b0; irq_ack_i = 1'b0; flag_we_i = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(8 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      rst_n = 1'b0; op_i = 4'd15; opa_i = '0; opb_i = '0; bitsel_i = '0;
      flag_we_i = 0; irq_ack_i = 0; bus_wr_i = 0; bus_addr_i = 8'h5F; bus_wdata_i = '0;
      repeat (3) @(posedge clk);
      #2;
      m_sreg = 8'h00;
      chk("R1 reset value", sreg_o, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); #2;

      // R2 directed: 0x7F+0x01 -> 0x80 with H,V,N set, S clear
      step("R2 add overflow", 0, 8'h7F, 8'h01, 0, 1, 0, 0, 8'h00, 8'h00);
      chk("R2 add flags exact", sreg_o, 8'h2C);
      step("R2 add carry to zero", 0, 8'hFF, 8'h01, 0, 1, 0, 0, 8'h00, 8'h00);
      step("R2 adc with carry", 1, 8'h10, 8'h0F, 0, 1, 0, 0, 8'h00, 8'h00);
      // R3 directed: 0x00-0x01 borrows
      step("R3 sub borrow", 2, 8'h00, 8'h01, 0, 1, 0, 0, 8'h00, 8'h00);
      chk("R3 sub flags exact", sreg_o, 8'h35);
      step("R3 sbc borrow-in", 3, 8'h80, 8'h00, 0, 1, 0, 0, 8'h00, 8'h00);
      step("R5 and keeps C H", 4, 8'hF0, 8'h0F, 0, 1, 0, 0, 8'h00, 8'h00);
      step("R6 no strobe holds", 0, 8'hFF, 8'hFF, 0, 0, 0, 0, 8'h00, 8'h00);
      step("R6 mov keeps flags", 7, 8'h00, 8'hA5, 0, 1, 0, 0, 8'h00, 8'h00);
      step("R7 bst copies 1", 8, 8'h20, 8'h00, 5, 1, 0, 0, 8'h00, 8'h00);
      step("R8 bld writes T", 9, 8'h00, 8'h00, 3, 1, 0, 0, 8'h00, 8'h00);
      chk("R8 bld result exact", result_o, 8'h08);
      step("R9 sei", 10, 8'h00, 8'h00, 0, 1, 0, 0, 8'h00, 8'h00);
      step("R10 irq beats reti", 12, 8'h00, 8'h00, 0, 1, 1, 0, 8'h00, 8'h00);
      step("R9 reti sets I", 12, 8'h00, 8'h00, 0, 1, 0, 0, 8'h00, 8'h00);
      step("R9 cli", 11, 8'h00, 8'h00, 0, 1, 0, 0, 8'h00, 8'h00);
      step("R12 bus write other addr ignored", 15, 8'h00, 8'h00, 0, 0, 0, 1, 8'h3F, 8'hFF);
      step("R12 bus write beats op and irq", 0, 8'h01, 8'h01, 0, 1, 1, 1, 8'h5F, 8'hC3);
      chk("R12 bus write value", sreg_o, 8'hC3);
      step("R11 bus read back", 15, 8'h00, 8'h00, 0, 0, 0, 0, 8'h5F, 8'h00);
      step("R11 bus read miss", 15, 8'h00, 8'h00, 0, 0, 0, 0, 8'h5E, 8'h00);

      for (int n = 0; n < 400; n++) begin
         int op;
         logic we, irq, bwr;
         logic [7:0] baddr;
         op    = int'($urandom_range(0, 15));
         we    = ($urandom_range(0, 3) != 0);
         irq   = ($urandom_range(0, 7) == 0);
         bwr   = ($urandom_range(0, 11) == 0);
         baddr = ($urandom_range(0, 1) == 0) ? 8'h5F : 8'($urandom_range(0, 255));
         step("R4 random", op, 8'($urandom), 8'($urandom), int'($urandom_range(0, 7)),
              we, irq, bwr, baddr, 8'($urandom));
      end

      summary();
      $finish;
   end

endmodule